// File: doc/BRIEF.md
# Arithmetic-Logic Unit with Status Flags and Branch Test

This block combines a combinational two's-complement arithmetic-logic unit with a four-bit registered status word and a branch-condition test. A caller presents an operation code and two operands together with a valid strobe. The result appears on the same cycle, alongside a write-back qualifier. The status word (negative, zero, overflow, carry) is captured on the next rising clock edge, but only for operations defined to affect it. Carry-in for the chained add and subtract comes from the stored carry. This allows multi-word arithmetic to be built from successive operations.

The status word is combined with a three-bit condition selector to produce a single taken bit for a conditional branch. Compare and test operations exist only to set the status word: they compute a difference or a mask but do not request write-back. Three carry-manipulation operations clear, set or invert the carry bit and touch nothing else.

There is no sequencer. The only state is the status register, which has two phases: held (no qualifying operation) and loaded (a qualifying operation on the previous edge). The loaded update takes one of three forms, chosen by the operation class: full update, logic update or carry-only update.

Top module: `alu_flags_unit`

## Requirements
- R1: Operation codes are ADD=0, ADC=1, SUB=2, SBB=3, NEG=8 (0 minus A). The result is the sum or difference modulo 2^WIDTH, and `res_wr` is 1 for these codes when `op_valid` is 1.
- R2: AND=4, OR=5, XOR=6 and NOT=7 (bitwise complement of A) give the bitwise result with `res_wr`=1.
- R3: After an arithmetic or compare operation, V (status bit 1) is 1 exactly when the carry into the top bit differs from the carry out of it, i.e. same-signed operands gave a result of the other sign.
- R4: After any operation other than the carry controls, N (bit 3) equals the result's top bit and Z (bit 2) is 1 exactly when every result bit is 0.
- R5: C (bit 0) is the adder's carry out. Subtraction adds the inverted B plus one, so 0xF0 minus 0x14 gives 0xDC with N=1, Z=0, V=0, C=1.
- R6: ADC adds the stored C as carry-in. SBB adds the inverted B plus the stored C, so stored C=0 subtracts one more.
- R7: CMP=9 (A minus B) and TST=10 (A AND B) update all flags as SUB and AND would, with `res_wr`=0.
- R8: AND, OR, XOR, NOT and TST clear V and leave C unchanged.
- R9: CLC=11, STC=12 and CMC=13 make C 0, 1 or its inverse, leave N, Z and V unchanged, and give `res_wr`=0.
- R10: The status word changes only on a clock edge where `op_valid` is 1 and the code is 0 to 13. Codes 14 and 15, or `op_valid`=0, leave it unchanged with `res_wr`=0.
- R11: `br_taken` for `br_cond` 0..7 is Z, !Z, C, !C, !N, N, V, !V.
- R12: While `rst_n` is low the status word is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 4 | Operation code |
| opnd_a | input | WIDTH | First operand |
| opnd_b | input | WIDTH | Second operand |
| result | output | WIDTH | Combinational result |
| res_wr | output | 1 | Result is meant to be written back |
| flags_q | output | 4 | Stored status {N,Z,V,C} |
| br_cond | input | 3 | Branch condition selector |
| br_taken | output | 1 | Branch condition holds |

## Verification
A corrupted status bit shows up in two ways. It appears on `flags_q` one edge after the operation that wrote it. It also appears on `br_taken` for the conditions that use that bit, from the same moment. A wrong stored carry also spreads into the next ADC or SBB result on the same cycle that operation is presented. Each check therefore looks at the result before the edge and at the status word and every branch condition after it. A stale or wrongly held flag is caught within one operation.

// File: rtl/alu_flags_pkg.sv
package alu_flags_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADC  = 4'd1,
        OP_SUB  = 4'd2,
        OP_SBB  = 4'd3,
        OP_AND  = 4'd4,
        OP_OR   = 4'd5,
        OP_XOR  = 4'd6,
        OP_NOT  = 4'd7,
        OP_NEG  = 4'd8,
        OP_CMP  = 4'd9,
        OP_TST  = 4'd10,
        OP_CLC  = 4'd11,
        OP_STC  = 4'd12,
        OP_CMC  = 4'd13,
        OP_NOP0 = 4'd14,
        OP_NOP1 = 4'd15
    } alu_op_e;

    // How an operation touches the status word
    typedef enum logic [1:0] {
        FW_NONE  = 2'd0,
        FW_FULL  = 2'd1,
        FW_LOGIC = 2'd2,
        FW_CARRY = 2'd3
    } flag_cls_e;

    typedef struct packed {
        logic neg;
        logic zero;
        logic ovf;
        logic cy;
    } flag_set_t;

    function automatic flag_cls_e op_class(input alu_op_e op);
        case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_NEG, OP_CMP: op_class = FW_FULL;
            OP_AND, OP_OR, OP_XOR, OP_NOT, OP_TST:          op_class = FW_LOGIC;
            OP_CLC, OP_STC, OP_CMC:                         op_class = FW_CARRY;
            default:                                        op_class = FW_NONE;
        endcase
    endfunction

endpackage

// File: rtl/alu_datapath.sv
module alu_datapath
    import alu_flags_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  alu_op_e          op,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cy_stored,
    output logic [WIDTH-1:0] res,
    output logic             res_is_wb,
    output flag_set_t        flg_nxt
);
    localparam int LW = WIDTH - 1;

    logic [WIDTH-1:0] add_x;
    logic [WIDTH-1:0] add_y;
    logic             add_ci;
    logic [LW-1:0]    low_sum;
    logic             c_into_msb;
    logic             msb_sum;
    logic             c_out_msb;
    logic [WIDTH-1:0] add_res;
    logic             is_arith;

    // Operand steering for the adder
    always_comb begin
        add_x    = a;
        add_y    = b;
        add_ci   = 1'b0;
        is_arith = 1'b1;
        unique case (op)
            OP_ADD: begin add_y = b;  add_ci = 1'b0;      end
            OP_ADC: begin add_y = b;  add_ci = cy_stored; end
            OP_SUB,
            OP_CMP: begin add_y = ~b; add_ci = 1'b1;      end
            OP_SBB: begin add_y = ~b; add_ci = cy_stored; end
            OP_NEG: begin add_x = '0; add_y = ~a; add_ci = 1'b1; end
            default: is_arith = 1'b0;
        endcase
    end

    // Adder split at the top bit so both carries are visible
    assign {c_into_msb, low_sum} = {1'b0, add_x[LW-1:0]} + {1'b0, add_y[LW-1:0]}
                                 + {{LW{1'b0}}, add_ci};
    assign {c_out_msb, msb_sum}  = {1'b0, add_x[WIDTH-1]} + {1'b0, add_y[WIDTH-1]}
                                 + {1'b0, c_into_msb};
    assign add_res = {msb_sum, low_sum};

    always_comb begin
        res       = '0;
        res_is_wb = 1'b0;
        flg_nxt   = '{neg: 1'b0, zero: 1'b0, ovf: 1'b0, cy: cy_stored};
        unique case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_NEG, OP_CMP: begin
                res       = add_res;
                res_is_wb = (op != OP_CMP);
                flg_nxt.ovf = c_into_msb ^ c_out_msb;
                flg_nxt.cy  = c_out_msb;
            end
            OP_AND, OP_TST: begin
                res       = a & b;
                res_is_wb = (op != OP_TST);
            end
            OP_OR:  begin res = a | b; res_is_wb = 1'b1; end
            OP_XOR: begin res = a ^ b; res_is_wb = 1'b1; end
            OP_NOT: begin res = ~a;    res_is_wb = 1'b1; end
            OP_CLC: flg_nxt.cy = 1'b0;
            OP_STC: flg_nxt.cy = 1'b1;
            OP_CMC: flg_nxt.cy = ~cy_stored;
            default: ;
        endcase
        flg_nxt.neg  = res[WIDTH-1];
        flg_nxt.zero = (res == '0);
    end

    wire unused_arith = is_arith;

endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
    import alu_flags_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      upd_en,
    input  flag_cls_e cls,
    input  flag_set_t flg_nxt,
    output flag_set_t flg_q
);
    flag_set_t flg_d;

    always_comb begin
        flg_d = flg_q;
        if (upd_en) begin
            unique case (cls)
                FW_FULL:  flg_d = flg_nxt;
                FW_LOGIC: flg_d = '{neg: flg_nxt.neg, zero: flg_nxt.zero,
                                    ovf: 1'b0, cy: flg_q.cy};
                FW_CARRY: flg_d.cy = flg_nxt.cy;
                FW_NONE:  flg_d = flg_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flg_q <= '0;
        else        flg_q <= flg_d;
    end

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_en || cls == FW_NONE) |=> $stable(flg_q));

    p_carry_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && cls == FW_CARRY) |=> ($stable(flg_q.neg) && $stable(flg_q.zero)
                                         && $stable(flg_q.ovf)));

    p_logic_keeps_c_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && cls == FW_LOGIC) |=> (!flg_q.ovf && $stable(flg_q.cy)));

    p_nz_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && (cls == FW_FULL || cls == FW_LOGIC)) |=> !(flg_q.neg && flg_q.zero));

endmodule

// File: rtl/alu_cond_eval.sv
module alu_cond_eval
    import alu_flags_pkg::*;
(
    input  flag_set_t  flg,
    input  logic [2:0] sel,
    output logic       taken
);
    logic base;

    // Bit 0 of the selector inverts the tested flag; bits 2:1 pick it
    always_comb begin
        unique case (sel[2:1])
            2'd0: base = flg.zero;
            2'd1: base = flg.cy;
            2'd2: base = ~flg.neg;
            2'd3: base = flg.ovf;
        endcase
        taken = base ^ sel[0];
    end

endmodule

// File: rtl/alu_flags_unit.sv
module alu_flags_unit
    import alu_flags_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [3:0]       op_code,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    output logic [WIDTH-1:0] result,
    output logic             res_wr,
    output logic [3:0]       flags_q,
    input  logic [2:0]       br_cond,
    output logic             br_taken
);
    alu_op_e   op;
    flag_set_t flg_nxt;
    flag_set_t flg_q;
    flag_cls_e cls;
    logic      wb_raw;

    assign op  = alu_op_e'(op_code);
    assign cls = op_class(op);

    alu_datapath #(.WIDTH(WIDTH)) u_dp (
        .op        (op),
        .a         (opnd_a),
        .b         (opnd_b),
        .cy_stored (flg_q.cy),
        .res       (result),
        .res_is_wb (wb_raw),
        .flg_nxt   (flg_nxt)
    );

    alu_flag_reg u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd_en  (op_valid),
        .cls     (cls),
        .flg_nxt (flg_nxt),
        .flg_q   (flg_q)
    );

    alu_cond_eval u_cond (
        .flg   (flg_q),
        .sel   (br_cond),
        .taken (br_taken)
    );

    assign res_wr  = op_valid & wb_raw;
    assign flags_q = flg_q;

    p_add_ovf_sign_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == OP_ADD && flg_nxt.ovf) |->
        (opnd_a[WIDTH-1] == opnd_b[WIDTH-1] && result[WIDTH-1] != opnd_a[WIDTH-1]));

    p_sub_ovf_sign_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == OP_SUB && flg_nxt.ovf) |->
        (opnd_a[WIDTH-1] != opnd_b[WIDTH-1] && result[WIDTH-1] != opnd_a[WIDTH-1]));

    p_no_wb_cmp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_CMP || op == OP_TST) |-> !res_wr);

endmodule

// File: tb/alu_flags_unit_tb.sv
module alu_flags_unit_tb_top;
    localparam int W = 8;
    localparam real HALF = 2.5;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         op_valid = 1'b0;
    logic [3:0]   op_code = 4'd0;
    logic [W-1:0] opnd_a = '0;
    logic [W-1:0] opnd_b = '0;
    logic [W-1:0] result;
    logic         res_wr;
    logic [3:0]   flags_q;
    logic [2:0]   br_cond = 3'd0;
    logic         br_taken;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [3:0] mflags = 4'd0;   // model of {N,Z,V,C}

    always #(HALF) clk = ~clk;

    alu_flags_unit #(.WIDTH(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result), .res_wr(res_wr),
        .flags_q(flags_q), .br_cond(br_cond), .br_taken(br_taken)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // returns {wr, result, new flags}
    function automatic logic [W+4:0] model(input logic [3:0] op, input logic [W-1:0] a,
                                           input logic [W-1:0] b, input logic [3:0] f,
                                           input bit vld);
        logic [W-1:0] x, y, r;
        logic [W:0]   s;
        logic         ci, wr;
        logic [3:0]   nf;
        bit           arith;
        x = a; y = b; ci = 1'b0; arith = 1'b1; r = '0; wr = 1'b0; nf = f;
        case (op)
            4'd0: begin ci = 1'b0; end
            4'd1: begin ci = f[0]; end
            4'd2, 4'd9: begin y = ~b; ci = 1'b1; end
            4'd3: begin y = ~b; ci = f[0]; end
            4'd8: begin x = '0; y = ~a; ci = 1'b1; end
            default: arith = 1'b0;
        endcase
        if (arith) begin
            s = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
            r = s[W-1:0];
            wr = (op != 4'd9);
            nf = {r[W-1], r == '0, (x[W-1] == y[W-1]) && (r[W-1] != x[W-1]), s[W]};
        end else begin
            case (op)
                4'd4, 4'd10: r = a & b;
                4'd5: r = a | b;
                4'd6: r = a ^ b;
                4'd7: r = ~a;
                default: r = '0;
            endcase
            if (op >= 4'd4 && op <= 4'd7) wr = 1'b1;
            if ((op >= 4'd4 && op <= 4'd7) || op == 4'd10)
                nf = {r[W-1], r == '0, 1'b0, f[0]};
            else if (op == 4'd11) nf = {f[3:1], 1'b0};
            else if (op == 4'd12) nf = {f[3:1], 1'b1};
            else if (op == 4'd13) nf = {f[3:1], ~f[0]};
        end
        if (!vld) begin wr = 1'b0; nf = f; end
        return {wr, r, nf};
    endfunction

    function automatic bit cond_exp(input logic [2:0] c, input logic [3:0] f);
        case (c)
            3'd0: return f[2];
            3'd1: return !f[2];
            3'd2: return f[0];
            3'd3: return !f[0];
            3'd4: return !f[3];
            3'd5: return f[3];
            3'd6: return f[1];
            default: return !f[1];
        endcase
    endfunction

    function automatic string tag_of(input logic [3:0] op);
        if (op <= 4'd3 || op == 4'd8) return "R1/R3/R5/R6";
        if (op <= 4'd7) return "R2/R8";
        if (op <= 4'd10) return "R7";
        if (op <= 4'd13) return "R9";
        return "R10";
    endfunction

    task automatic run_op(input logic [3:0] op, input logic [W-1:0] a,
                          input logic [W-1:0] b, input bit vld);
        logic [W+4:0] e;
        @(negedge clk);
        op_valid = vld; op_code = op; opnd_a = a; opnd_b = b;
        e = model(op, a, b, mflags, vld);
        #1;
        chk(res_wr == e[W+4], {tag_of(op), " res_wr"}, res_wr, e[W+4]);
        if (e[W+4]) chk(result == e[W+3:4], {tag_of(op), " result"}, result, e[W+3:4]);
        @(posedge clk);
        #1;
        mflags = e[3:0];
        op_valid = 1'b0;
        chk(flags_q == mflags, {tag_of(op), " R4 flags"}, flags_q, mflags);
        br_cond = 3'($urandom_range(0, 7));
        #1;
        chk(br_taken == cond_exp(br_cond, mflags), "R11 br_taken", br_taken,
            cond_exp(br_cond, mflags));
    endtask

    task automatic sweep_cond();
        for (int c = 0; c < 8; c++) begin
            br_cond = 3'(c);
            #1;
            chk(br_taken == cond_exp(3'(c), mflags), "R11 cond sweep", br_taken,
                cond_exp(3'(c), mflags));
        end
    endtask

    initial begin
        #(HALF * 2 * 150000);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(posedge clk);
        #1;
        chk(flags_q == 4'd0, "R12 reset flags", flags_q, 0);
        sweep_cond();
        @(negedge clk);
        rst_n = 1'b1;

        // Directed corners
        run_op(4'd2, 8'hF0, 8'h14, 1'b1);              // R5 example
        chk(flags_q == 4'b1001, "R5 F0-14 flags", flags_q, 4'b1001);
        run_op(4'd0, 8'h7F, 8'h01, 1'b1);              // R3 positive overflow
        chk(flags_q[1] == 1'b1, "R3 7F+1 V", flags_q[1], 1);
        run_op(4'd2, 8'h80, 8'h01, 1'b1);              // R3 negative overflow
        run_op(4'd0, 8'h80, 8'h80, 1'b1);              // R4 zero with carry and V
        chk(flags_q == 4'b0111, "R4 80+80 flags", flags_q, 4'b0111);
        sweep_cond();
        run_op(4'd1, 8'hFF, 8'h00, 1'b1);              // R6 ADC with stored C=1
        run_op(4'd11, 8'h00, 8'h00, 1'b1);             // R9 CLC
        run_op(4'd3, 8'h10, 8'h01, 1'b1);              // R6 SBB with C=0
        run_op(4'd12, 8'h00, 8'h00, 1'b1);             // R9 STC
        run_op(4'd13, 8'h00, 8'h00, 1'b1);             // R9 CMC
        run_op(4'd9, 8'h33, 8'h33, 1'b1);              // R7 compare equal
        run_op(4'd12, 8'h00, 8'h00, 1'b1);
        run_op(4'd10, 8'hB1, 8'h08, 1'b1);             // R7 R8 test mask zero
        run_op(4'd8, 8'h80, 8'h00, 1'b1);              // R1 negate most negative
        run_op(4'd8, 8'h00, 8'h00, 1'b1);
        run_op(4'd7, 8'h5A, 8'h00, 1'b1);              // R2 complement
        run_op(4'd14, 8'h00, 8'h00, 1'b1);             // R10 no-op codes
        run_op(4'd15, 8'hFF, 8'hFF, 1'b1);
        run_op(4'd2, 8'h01, 8'h02, 1'b0);              // R10 op_valid low
        sweep_cond();

        // Random mix
        for (int i = 0; i < 600; i++) begin
            run_op(4'($urandom_range(0, 15)), W'($urandom), W'($urandom),
                   ($urandom_range(0, 7) != 0));
        end
        sweep_cond();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule